// File: doc/BRIEF.md
# Cascadable Signed/Unsigned Magnitude Comparator

This block compares two 16-bit operands with no clock or storage. It reports three relation flags: less-than, equal and greater-than. It also produces a 16-bit set-less-than word, which an ALU can write back directly for a set-on-less-than style instruction.

The datapath is a chain of identical 4-bit comparison slices. Each slice resolves its own bit pairs from the most significant bit downward. A slice passes on the relation it receives from the slice below only when all of its own bit pairs match. The bottom slice receives a constant "equal" relation, so its own bits alone decide its result. The chain ripples: the top slice's answer is final only after every lower slice has settled.

A mode input chooses between unsigned and two's-complement ordering. In signed mode the sign positions are reinterpreted, so that any negative operand orders below any non-negative one. Slices and lower bits behave the same in both modes.

Top module: `magcmp_chain`

## Requirements
- R1: With `signed_mode` = 0, exactly one of `is_less`, `is_equal` and `is_greater` is high. That flag matches the unsigned ordering of `op_a` against `op_b`.
- R2: With `signed_mode` = 1, the flags follow the two's-complement ordering of `op_a` against `op_b`, where bit 15 is the sign.
- R3: For every input pair and mode, exactly one of the three relation flags is high.
- R4: `slt_word` is 16'h0001 when `is_less` is high and 16'h0000 otherwise. Bits 15 to 1 are always zero.
- R5: When `op_a` equals `op_b`, `is_equal` is high in either mode.
- R6: The most significant differing bit decides the result, even when it lies in a higher slice than every differing lower bit. For example, 16'h1000 against 16'h0FFF gives greater-than in unsigned mode.
- R7: When the sign bits differ, the negative operand is less in signed mode and greater in unsigned mode. For example, 16'h8000 against 16'h7FFF gives less-than with `signed_mode` = 1 and greater-than with `signed_mode` = 0.
- R8: When bit 15 of both operands is the same, `signed_mode` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Left operand |
| op_b | input | 16 | Right operand |
| signed_mode | input | 1 | 1 = two's-complement ordering, 0 = unsigned |
| is_less | output | 1 | op_a orders below op_b |
| is_equal | output | 1 | op_a equals op_b |
| is_greater | output | 1 | op_a orders above op_b |
| slt_word | output | 16 | Zero-extended less-than result |

## Verification
The hardest case to reach is one where only the bottom slice decides the result. This needs every upper nibble to match while the lowest nibble differs, and uniformly random operands almost never produce it. The stimulus therefore derives half of its `op_b` values from `op_a` by changing a single randomly chosen nibble. This makes the deciding slice land evenly across the chain, including the bottom one. Directed pairs cover the sign-boundary values in both modes, and the same pair is applied under both modes to show that the mode is neutral when the sign bits agree.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    localparam rel_t REL_EQ = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
    localparam rel_t REL_LT = '{lt: 1'b1, eq: 1'b0, gt: 1'b0};
    localparam rel_t REL_GT = '{lt: 1'b0, eq: 1'b0, gt: 1'b1};

    // Relation implied by a single differing bit pair (a-bit set means a is larger).
    function automatic rel_t rel_from_bit(input logic a_bit);
        return a_bit ? REL_GT : REL_LT;
    endfunction

endpackage

// File: rtl/magcmp_sign_prep.sv
module magcmp_sign_prep
    import magcmp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);
    localparam int MSB = DATA_W - 1;

    // Inverting both sign bits turns two's-complement order into unsigned order.
    always_comb begin
        a_o      = a_i;
        b_o      = b_i;
        a_o[MSB] = a_i[MSB] ^ signed_i;
        b_o[MSB] = b_i[MSB] ^ signed_i;
    end

    always_comb begin
        if (a_i[MSB] == b_i[MSB]) begin
            p_mode_neutral_r8: assert ((a_o ^ b_o) == (a_i ^ b_i));
        end
    end

endmodule

// File: rtl/magcmp_slice.sv
module magcmp_slice
    import magcmp_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  rel_t               casc_i,
    output rel_t               rel_o
);

    // Scan from the top bit; the first mismatch wins, otherwise pass the cascade.
    always_comb begin
        logic hit;
        hit   = 1'b0;
        rel_o = casc_i;
        for (int i = SLICE_W - 1; i >= 0; i--) begin
            if (!hit && (a_i[i] != b_i[i])) begin
                hit   = 1'b1;
                rel_o = rel_from_bit(a_i[i]);
            end
        end
    end

    always_comb begin
        if (a_i == b_i) begin
            p_slice_passthru_r6: assert (rel_o == casc_i);
        end else begin
            p_slice_local_r6: assert (rel_o.eq == 1'b0);
        end
    end

endmodule

// File: rtl/magcmp_slt_ext.sv
module magcmp_slt_ext #(
    parameter int DATA_W = 16
) (
    input  logic              less_i,
    output logic [DATA_W-1:0] word_o
);

    always_comb begin
        word_o    = '0;
        word_o[0] = less_i;
    end

endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SLICE_W = 4
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              signed_mode,
    output logic              is_less,
    output logic              is_equal,
    output logic              is_greater,
    output logic [DATA_W-1:0] slt_word
);
    localparam int N_SLICES = DATA_W / SLICE_W;

    logic [DATA_W-1:0] a_m;
    logic [DATA_W-1:0] b_m;
    rel_t              chain [0:N_SLICES];

    magcmp_sign_prep #(.DATA_W(DATA_W)) u_prep (
        .a_i      (op_a),
        .b_i      (op_b),
        .signed_i (signed_mode),
        .a_o      (a_m),
        .b_o      (b_m)
    );

    // Bottom slice sees a fixed "equal" so only its own bits matter.
    assign chain[0] = REL_EQ;

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        magcmp_slice #(.SLICE_W(SLICE_W)) u_slice (
            .a_i    (a_m[s*SLICE_W +: SLICE_W]),
            .b_i    (b_m[s*SLICE_W +: SLICE_W]),
            .casc_i (chain[s]),
            .rel_o  (chain[s+1])
        );
    end

    assign is_less    = chain[N_SLICES].lt;
    assign is_equal   = chain[N_SLICES].eq;
    assign is_greater = chain[N_SLICES].gt;

    magcmp_slt_ext #(.DATA_W(DATA_W)) u_slt (
        .less_i (is_less),
        .word_o (slt_word)
    );

    always_comb begin
        p_one_flag_r3: assert ($onehot({is_less, is_equal, is_greater}));
        p_slt_ext_r4: assert (slt_word == {{(DATA_W-1){1'b0}}, is_less});
        if (op_a == op_b) begin
            p_equal_ops_r5: assert (is_equal);
        end
    end

endmodule

// File: tb/magcmp_chain_bench.sv
module magcmp_chain_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        signed_mode = 1'b0;
    logic        is_less, is_equal, is_greater;
    logic [15:0] slt_word;

    int n_vec  = 0;
    int n_fail = 0;
    int wd     = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    magcmp_chain u_magcmp_chain (
        .op_a        (op_a),
        .op_b        (op_b),
        .signed_mode (signed_mode),
        .is_less     (is_less),
        .is_equal    (is_equal),
        .is_greater  (is_greater),
        .slt_word    (slt_word)
    );

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    // Behavioural reference: integer comparison of the operands under the mode.
    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic m, input string tag);
        int ia, ib;
        logic el, ee, eg;
        logic [15:0] ew;
        bit bad;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; signed_mode = m;
        ia = m ? int'($signed(a)) : int'(a);
        ib = m ? int'($signed(b)) : int'(b);
        el = (ia < ib); ee = (ia == ib); eg = (ia > ib);
        ew = {15'b0, el};
        @(negedge clk);
        n_vec++;
        bad = 0;
        if ({is_less, is_equal, is_greater} !== {el, ee, eg}) begin
            bad = 1;
            $display("FAIL %s flags a=%h b=%h m=%0b: actual=%b expected=%b",
                     tag, a, b, m, {is_less, is_equal, is_greater}, {el, ee, eg});
        end
        if (!$onehot({is_less, is_equal, is_greater})) begin
            bad = 1;
            $display("FAIL R3 one-flag a=%h b=%h: actual=%b expected=onehot",
                     a, b, {is_less, is_equal, is_greater});
        end
        if (slt_word !== ew) begin
            bad = 1;
            $display("FAIL R4 slt_word a=%h b=%h m=%0b: actual=%h expected=%h", a, b, m, slt_word, ew);
        end
        if (bad) n_fail++;
    endtask

    // R8: same pair in both modes when sign bits agree gives identical outputs.
    task automatic mode_pair(input logic [15:0] a, input logic [15:0] b);
        logic [18:0] r0;
        apply(a, b, 1'b0, "R1");
        r0 = {is_less, is_equal, is_greater, slt_word};
        apply(a, b, 1'b1, "R2");
        n_vec++;
        if ({is_less, is_equal, is_greater, slt_word} !== r0) begin
            n_fail++;
            $display("FAIL R8 mode effect a=%h b=%h: actual=%h expected=%h",
                     a, b, {is_less, is_equal, is_greater, slt_word}, r0);
        end
    endtask

    initial begin
        logic [15:0] a, b;
        int k;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: zero operands compare equal (R5).
        apply(16'h0000, 16'h0000, 1'b0, "R5");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R5");
        apply(16'h8000, 16'h8000, 1'b1, "R5");
        // R6: the higher slice outranks every lower bit.
        apply(16'h1000, 16'h0FFF, 1'b0, "R6");
        apply(16'h00F0, 16'h010F, 1'b0, "R6");
        apply(16'h1231, 16'h1230, 1'b0, "R6");
        apply(16'h1230, 16'h1231, 1'b0, "R6");
        // R7: differing sign bits in both modes.
        apply(16'h8000, 16'h7FFF, 1'b1, "R7");
        apply(16'h8000, 16'h7FFF, 1'b0, "R7");
        apply(16'h0000, 16'hFFFF, 1'b1, "R7");
        apply(16'h0000, 16'hFFFF, 1'b0, "R7");
        // R8: matching sign bits.
        mode_pair(16'h7FFE, 16'h7FFF);
        mode_pair(16'hFFFE, 16'h8001);
        mode_pair(16'h4321, 16'h4321);
        // Random sweep; half the pairs differ in one nibble only.
        for (int i = 0; i < 4000; i++) begin
            a = 16'($urandom);
            if (i % 2 == 0) begin
                b = 16'($urandom);
            end else begin
                k = int'($urandom % 4);
                b = a;
                b[k*4 +: 4] = 4'($urandom);
            end
            if (a[15] == b[15] && i % 7 == 0) mode_pair(a, b);
            else apply(a, b, i[2], i[2] ? "R2" : "R1");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule